// File: doc/BRIEF.md
# Quarter-Period IQ Demodulator with Vectoring CORDIC

The block takes a stream of signed ADC samples of an intermediate-frequency carrier sampled at four fifths of the carrier rate, so that each sample sits 90 degrees after the one before it. Over any four accepted samples the stream therefore carries the in-phase value, the quadrature value, the negated in-phase value and the negated quadrature value. A small slot state machine follows that position, undoes the sign inversion on the second half of each group, and emits one in-phase/quadrature pair for every two accepted samples.

Each pair goes through a quadrant pre-rotation and a fully pipelined vectoring CORDIC, one stage per iteration. That yields the unscaled magnitude and the angle of the vector. An output stage then rounds both results and adds a programmable phase offset, with wrap-around. The sequence is realigned by a resync input, which sends the slot machine back to the in-phase slot.

The slot machine has four states: SLOT_I, SLOT_Q, SLOT_NI and SLOT_NQ. Reset enters SLOT_I. Each accepted sample moves the machine one step along the ring SLOT_I to SLOT_Q to SLOT_NI to SLOT_NQ and back to SLOT_I. A cycle with the sample valid low leaves the state unchanged. Resync forces SLOT_I from any state.

Top module: `iq_demod`

## Requirements
- R1: While reset is high and in the first cycle after it is released, out_valid is 0, out_amp is 0 and out_phase is 0, and the slot machine is in SLOT_I.
- R2: Accepted samples fill the slots in the fixed order SLOT_I, SLOT_Q, SLOT_NI, SLOT_NQ. A sample in SLOT_I is taken as I and a sample in SLOT_Q is taken as Q. A sample in SLOT_NI is negated and taken as I, and a sample in SLOT_NQ is negated and taken as Q.
- R3: A pair is formed only when a sample is accepted in SLOT_Q or SLOT_NQ. Two pairs are never formed in consecutive cycles. A cycle with smp_vld low is ignored and does not move the slot.
- R4: out_valid pulses for one cycle exactly 18 clock edges (ITER+2) after the edge that accepted the sample closing a pair. Every pair produces exactly one strobe.
- R5: out_amp is the unscaled magnitude, 1.64676·sqrt(I²+Q²), within 2 LSB and rounded to an integer.
- R6: out_phase is atan2(Q,I) as 16-bit two's complement, with -32768 standing for -180 degrees and 32768 counts equal to 180 degrees. It is within 2 LSB, modulo 65536, in all four quadrants, including negative I near ±180 degrees.
- R7: ph_offset, a signed 16-bit value in the same units as out_phase, is added to the phase modulo 65536. The value used is the one present at the edge that raises out_valid.
- R8: When resync is high, the slot machine returns to SLOT_I. A sample accepted in the same cycle is taken as I, so no pair is formed in the following cycle.
- R9: Between strobes, out_amp and out_phase keep the values of the last strobe.
- R10: A full-scale negative sample (-32768) in any slot gives the correct magnitude and phase, with no overflow. This includes a negated value of +32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | The sample on smp_data is accepted this cycle |
| smp_data | input | 16 | Signed ADC sample |
| resync | input | 1 | Realign the slot sequence to the in-phase slot |
| ph_offset | input | 16 | Signed phase offset added to the result |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_amp | output | 18 | Unscaled magnitude |
| out_phase | output | 16 | Signed phase, full scale ±180 degrees |

## Verification
Every pair closes on an accepted SLOT_Q or SLOT_NQ sample, and its result is due on exactly the 18th edge after that acceptance. The bench's behavioural model tags each expected magnitude and phase with that due cycle as soon as it drives the closing sample. It compares on the falling edge of every clock: a strobe in any other cycle is a timing failure, and so is a missing strobe. In every cycle without a strobe the outputs are compared against the previous result. The phase offset changes only once the pipeline has drained, so each expectation is computed with the offset that will be in force at its due edge.

// File: rtl/iqd_pkg.sv
package iqd_pkg;

    typedef enum logic [1:0] {
        SLOT_I  = 2'd0,
        SLOT_Q  = 2'd1,
        SLOT_NI = 2'd2,
        SLOT_NQ = 2'd3
    } slot_e;

    localparam int ATAN_ENTRIES = 20;

    // arctan(2^-idx) with 2^31 standing for half a turn
    function automatic logic [31:0] atan_q31(input int idx);
        case (idx)
            0:  atan_q31 = 32'd536870912;
            1:  atan_q31 = 32'd316933406;
            2:  atan_q31 = 32'd167458907;
            3:  atan_q31 = 32'd85004756;
            4:  atan_q31 = 32'd42667331;
            5:  atan_q31 = 32'd21354465;
            6:  atan_q31 = 32'd10679838;
            7:  atan_q31 = 32'd5340245;
            8:  atan_q31 = 32'd2670163;
            9:  atan_q31 = 32'd1335087;
            10: atan_q31 = 32'd667544;
            11: atan_q31 = 32'd333772;
            12: atan_q31 = 32'd166886;
            13: atan_q31 = 32'd83443;
            14: atan_q31 = 32'd41722;
            15: atan_q31 = 32'd20861;
            16: atan_q31 = 32'd10430;
            17: atan_q31 = 32'd5215;
            18: atan_q31 = 32'd2608;
            19: atan_q31 = 32'd1304;
            default: atan_q31 = 32'd0;
        endcase
    endfunction

endpackage

// File: rtl/iqd_sorter.sv
module iqd_sorter
    import iqd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_vld,
    input  logic signed [DW-1:0] smp,
    input  logic                 resync,
    output logic                 pair_vld,
    output logic signed [DW:0]   pair_i,
    output logic signed [DW:0]   pair_q
);

    slot_e state;
    slot_e cur;
    slot_e nxt;

    logic signed [DW:0] ext;
    logic signed [DW:0] neg;
    logic signed [DW:0] hold_i;

    assign ext = {smp[DW-1], smp};
    assign neg = -ext;

    // resync overrides the stored slot for the sample of this cycle
    always_comb begin
        cur = resync ? SLOT_I : state;
    end

    always_comb begin
        nxt = cur;
        if (smp_vld) begin
            unique case (cur)
                SLOT_I:  nxt = SLOT_Q;
                SLOT_Q:  nxt = SLOT_NI;
                SLOT_NI: nxt = SLOT_NQ;
                SLOT_NQ: nxt = SLOT_I;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SLOT_I;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_vld <= 1'b0;
            pair_i   <= '0;
            pair_q   <= '0;
            hold_i   <= '0;
        end else begin
            pair_vld <= 1'b0;
            if (smp_vld) begin
                unique case (cur)
                    SLOT_I: begin
                        hold_i <= ext;
                    end
                    SLOT_Q: begin
                        pair_vld <= 1'b1;
                        pair_i   <= hold_i;
                        pair_q   <= ext;
                    end
                    SLOT_NI: begin
                        hold_i <= neg;
                    end
                    SLOT_NQ: begin
                        pair_vld <= 1'b1;
                        pair_i   <= hold_i;
                        pair_q   <= neg;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/iqd_cordic_step.sv
module iqd_cordic_step #(
    parameter int             XW  = 23,
    parameter int             ZW  = 20,
    parameter int             SH  = 0,
    parameter logic [ZW-1:0]  ANG = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vld_i,
    input  logic signed [XW-1:0] x_i,
    input  logic signed [XW-1:0] y_i,
    input  logic        [ZW-1:0] z_i,
    output logic                 vld_o,
    output logic signed [XW-1:0] x_o,
    output logic signed [XW-1:0] y_o,
    output logic        [ZW-1:0] z_o
);

    logic signed [XW-1:0] x_sh;
    logic signed [XW-1:0] y_sh;

    assign x_sh = x_i >>> SH;
    assign y_sh = y_i >>> SH;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            x_o   <= '0;
            y_o   <= '0;
            z_o   <= '0;
        end else begin
            vld_o <= vld_i;
            if (y_i[XW-1]) begin
                x_o <= x_i - y_sh;
                y_o <= y_i + x_sh;
                z_o <= z_i - ANG;
            end else begin
                x_o <= x_i + y_sh;
                y_o <= y_i - x_sh;
                z_o <= z_i + ANG;
            end
        end
    end

endmodule

// File: rtl/iqd_cordic.sv
module iqd_cordic
    import iqd_pkg::*;
#(
    parameter int DW   = 16,
    parameter int GB   = 4,
    parameter int ITER = 16,
    parameter int ZW   = 20
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_vld,
    input  logic signed [DW:0]          in_i,
    input  logic signed [DW:0]          in_q,
    output logic                        out_vld,
    output logic signed [DW+2+GB:0]     out_x,
    output logic        [ZW-1:0]        out_z
);

    localparam int XW = DW + 3 + GB;
    localparam logic [ZW-1:0] HALF_TURN = {1'b1, {(ZW-1){1'b0}}};

    logic signed [XW-1:0] xi;
    logic signed [XW-1:0] yi;

    logic                 vs [0:ITER];
    logic signed [XW-1:0] xs [0:ITER];
    logic signed [XW-1:0] ys [0:ITER];
    logic        [ZW-1:0] zs [0:ITER];

    assign xi = {{2{in_i[DW]}}, in_i, {GB{1'b0}}};
    assign yi = {{2{in_q[DW]}}, in_q, {GB{1'b0}}};

    // quadrant pre-rotation: a left half-plane vector is turned by half a turn
    always_ff @(posedge clk) begin
        if (rst) begin
            vs[0] <= 1'b0;
            xs[0] <= '0;
            ys[0] <= '0;
            zs[0] <= '0;
        end else begin
            vs[0] <= in_vld;
            if (in_i[DW]) begin
                xs[0] <= -xi;
                ys[0] <= -yi;
                zs[0] <= HALF_TURN;
            end else begin
                xs[0] <= xi;
                ys[0] <= yi;
                zs[0] <= '0;
            end
        end
    end

    for (genvar g = 0; g < ITER; g++) begin : g_step
        localparam logic [31:0]   A32 = atan_q31(g);
        localparam logic [ZW-1:0] AZ  = A32[31 -: ZW];

        iqd_cordic_step #(
            .XW  (XW),
            .ZW  (ZW),
            .SH  (g),
            .ANG (AZ)
        ) u_step (
            .clk   (clk),
            .rst   (rst),
            .vld_i (vs[g]),
            .x_i   (xs[g]),
            .y_i   (ys[g]),
            .z_i   (zs[g]),
            .vld_o (vs[g+1]),
            .x_o   (xs[g+1]),
            .y_o   (ys[g+1]),
            .z_o   (zs[g+1])
        );
    end

    assign out_vld = vs[ITER];
    assign out_x   = xs[ITER];
    assign out_z   = zs[ITER];

endmodule

// File: rtl/iqd_polar_out.sv
module iqd_polar_out #(
    parameter int XW = 23,
    parameter int ZW = 20,
    parameter int GB = 4,
    parameter int AW = 18,
    parameter int PW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic signed [XW-1:0] x,
    input  logic        [ZW-1:0] z,
    input  logic        [PW-1:0] offset,
    output logic                 out_vld,
    output logic        [AW-1:0] amp,
    output logic        [PW-1:0] phase
);

    localparam logic [XW-1:0] XHALF = XW'(1) << (GB - 1);
    localparam logic [ZW-1:0] ZHALF = ZW'(1) << (ZW - PW - 1);

    logic [AW-1:0] amp_n;
    logic [PW-1:0] ph_n;

    assign amp_n = AW'((x + XHALF) >>> GB);
    assign ph_n  = PW'((z + ZHALF) >> (ZW - PW)) + offset;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            amp     <= '0;
            phase   <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                amp   <= amp_n;
                phase <= ph_n;
            end
        end
    end

endmodule

// File: rtl/iq_demod.sv
module iq_demod #(
    parameter int DW   = 16,
    parameter int PW   = 16,
    parameter int ITER = 16,
    parameter int GB   = 4,
    parameter int GZ   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_vld,
    input  logic signed [DW-1:0] smp_data,
    input  logic                 resync,
    input  logic signed [PW-1:0] ph_offset,
    output logic                 out_valid,
    output logic        [DW+1:0] out_amp,
    output logic signed [PW-1:0] out_phase
);

    localparam int XW      = DW + 3 + GB;
    localparam int ZW      = PW + GZ;
    localparam int AW      = DW + 2;
    localparam int LATENCY = ITER + 2;

    logic                 pair_vld;
    logic signed [DW:0]   pair_i;
    logic signed [DW:0]   pair_q;
    logic                 cv;
    logic signed [XW-1:0] cx;
    logic        [ZW-1:0] cz;
    logic        [PW-1:0] ph_raw;

    iqd_sorter #(.DW(DW)) u_sort (
        .clk      (clk),
        .rst      (rst),
        .smp_vld  (smp_vld),
        .smp      (smp_data),
        .resync   (resync),
        .pair_vld (pair_vld),
        .pair_i   (pair_i),
        .pair_q   (pair_q)
    );

    iqd_cordic #(.DW(DW), .GB(GB), .ITER(ITER), .ZW(ZW)) u_cordic (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (pair_vld),
        .in_i    (pair_i),
        .in_q    (pair_q),
        .out_vld (cv),
        .out_x   (cx),
        .out_z   (cz)
    );

    iqd_polar_out #(.XW(XW), .ZW(ZW), .GB(GB), .AW(AW), .PW(PW)) u_out (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (cv),
        .x       (cx),
        .z       (cz),
        .offset  (ph_offset),
        .out_vld (out_valid),
        .amp     (out_amp),
        .phase   (ph_raw)
    );

    assign out_phase = ph_raw;

endmodule

// File: rtl/iqd_checker.sv
module iqd_checker #(
    parameter int LAT = 18,
    parameter int AW  = 18,
    parameter int PW  = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          smp_vld,
    input logic          resync,
    input logic          pair_vld,
    input logic          out_valid,
    input logic [AW-1:0] out_amp,
    input logic [PW-1:0] out_phase
);

    logic [LAT-1:0] trail;
    int             inflight;

    always_ff @(posedge clk) begin
        if (rst) begin
            trail    <= '0;
            inflight <= 0;
        end else begin
            trail    <= {trail[LAT-2:0], pair_vld};
            inflight <= inflight + (pair_vld ? 1 : 0) - (out_valid ? 1 : 0);
        end
    end

    a_r3_pair_spacing: assert property (@(posedge clk) disable iff (rst)
        pair_vld |=> !pair_vld);

    a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == trail[LAT-1]);

    a_r4_no_orphan: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> inflight > 0);

    a_r8_resync_slot_i: assert property (@(posedge clk) disable iff (rst)
        (resync && smp_vld) |=> !pair_vld);

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_amp) && $stable(out_phase)));

endmodule

bind iq_demod iqd_checker #(.LAT(LATENCY), .AW(DW + 2), .PW(PW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_vld   (smp_vld),
    .resync    (resync),
    .pair_vld  (pair_vld),
    .out_valid (out_valid),
    .out_amp   (out_amp),
    .out_phase (out_phase)
);

// File: tb/tb_iq_demod.sv
module tb_iq_demod;

    localparam int  LAT = 18;
    localparam real KG  = 1.646760258;
    localparam real PI  = 3.14159265358979;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               smp_vld = 1'b0;
    logic               resync = 1'b0;
    logic signed [15:0] smp_data = '0;
    logic signed [15:0] ph_offset = '0;
    logic               out_valid;
    logic        [17:0] out_amp;
    logic signed [15:0] out_phase;

    iq_demod dut (
        .clk       (clk),
        .rst       (rst),
        .smp_vld   (smp_vld),
        .smp_data  (smp_data),
        .resync    (resync),
        .ph_offset (ph_offset),
        .out_valid (out_valid),
        .out_amp   (out_amp),
        .out_phase (out_phase)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string ctx = "R1";
    int    q_due[$];
    int    q_amp[$];
    int    q_ph[$];
    int    slot = 0;
    int    held = 0;
    int    last_amp = 0;
    int    last_ph = 0;

    function automatic int wrap16(int v);
        int r;
        r = v & 65535;
        if (r >= 32768) r = r - 65536;
        return r;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_pair(int i, int q);
        real a;
        real p;
        a = KG * $sqrt(real'(i) * real'(i) + real'(q) * real'(q));
        p = $atan2(real'(q), real'(i)) / PI * 32768.0;
        q_due.push_back(cyc + 1 + LAT);
        q_amp.push_back(int'(a));
        q_ph.push_back(wrap16(int'(p) + int'(ph_offset)));
    endtask

    // behavioural slot model: one accepted sample per call
    task automatic put(int v, bit rs = 1'b0);
        @(negedge clk);
        smp_vld  = 1'b1;
        smp_data = 16'(v);
        resync   = rs;
        if (rs) slot = 0;
        case (slot)
            0: held = v;
            1: expect_pair(held, v);
            2: held = -v;
            default: expect_pair(held, -v);
        endcase
        slot = (slot + 1) % 4;
    endtask

    task automatic idle(int n);
        @(negedge clk);
        smp_vld = 1'b0;
        resync  = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic group(int i, int q);
        put(i);
        put(q);
        put(-i);
        put(-q);
    endtask

    task automatic vec(real a, real deg);
        int i;
        int q;
        i = int'(a * $cos(deg * PI / 180.0));
        q = int'(a * $sin(deg * PI / 180.0));
        group(i, q);
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (q_due.size() == 0 || q_due[0] != cyc) begin
                    check(1'b0, {ctx, " R4 unexpected strobe"}, cyc,
                          (q_due.size() == 0) ? -1 : q_due[0]);
                end else begin
                    check((int'(out_amp) - q_amp[0] <= 2) && (q_amp[0] - int'(out_amp) <= 2),
                          {ctx, " R5 amplitude"}, int'(out_amp), q_amp[0]);
                    check((wrap16(int'(out_phase) - q_ph[0]) <= 2) &&
                          (wrap16(int'(out_phase) - q_ph[0]) >= -2),
                          {ctx, " R6 phase"}, int'(out_phase), q_ph[0]);
                    void'(q_due.pop_front());
                    void'(q_amp.pop_front());
                    void'(q_ph.pop_front());
                end
                last_amp = int'(out_amp);
                last_ph  = int'(out_phase);
            end else begin
                if (q_due.size() > 0 && q_due[0] == cyc) begin
                    check(1'b0, {ctx, " R4 missing strobe"}, 0, cyc);
                    void'(q_due.pop_front());
                    void'(q_amp.pop_front());
                    void'(q_ph.pop_front());
                end
                check(int'(out_amp) == last_amp && int'(out_phase) == last_ph,
                      {ctx, " R9 hold"}, int'(out_phase), last_ph);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid && out_amp == 0 && out_phase == 0, "R1 outputs during reset",
              int'(out_amp), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && out_amp == 0 && out_phase == 0, "R1 outputs after reset",
              int'(out_amp), 0);

        // R2 R6: sweep through every quadrant, both halves of each group
        ctx = "R2 sweep";
        for (int d = 0; d < 360; d += 15) vec(20000.0, real'(d));
        idle(LAT + 4);

        // R5: several magnitudes
        ctx = "R5 magnitudes";
        vec(1500.0, 33.0);
        vec(32000.0, -70.0);
        vec(9000.0, 200.0);
        idle(LAT + 4);

        // R6: negative I close to the half-turn
        ctx = "R6 near half turn";
        vec(25000.0, 179.9);
        vec(25000.0, -179.9);
        vec(25000.0, 180.0);
        idle(LAT + 4);

        // R7: offset with wrap-around
        ctx = "R7 offset";
        ph_offset = 16'sd20000;
        vec(18000.0, 150.0);
        vec(18000.0, -40.0);
        idle(LAT + 4);
        ph_offset = -16'sd32768;
        vec(18000.0, 10.0);
        idle(LAT + 4);
        ph_offset = '0;

        // R3: gaps between samples neither shift the slot nor form pairs
        ctx = "R3 gaps";
        put(12000); idle(3);
        put(-5000); idle(1);
        put(-12000); idle(5);
        put(5000); idle(2);
        put(-300); idle(4);
        put(22000);
        idle(LAT + 4);

        // R8: resync mid-group restarts at the in-phase slot
        ctx = "R8 resync";
        put(1000);
        put(2000);
        put(3000);
        put(5000, 1'b1);
        put(7000);
        put(-4000);
        put(9000);
        idle(LAT + 4);

        // R10: full-scale negative samples in every slot
        ctx = "R10 full scale";
        put(-32768);
        put(0);
        put(-32768);
        put(-32768);
        idle(LAT + 4);

        // R4: back-to-back pairs keep exact spacing, nothing left over
        ctx = "R4 drain";
        vec(10000.0, 60.0);
        vec(10000.0, 61.0);
        idle(LAT + 6);
        check(q_due.size() == 0, "R4 all pairs produced", q_due.size(), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule